// File: doc/BRIEF.md
# Single-Cycle PI Phase Current Regulator

This block closes the current loop for one motor phase. Once per switching period a current sample arrives, taken at the centre of a symmetrical PWM period, with a one-clock valid strobe. On the same clock edge the block forms the error against the current reference and updates a clamped integrator. It adds the proportional and integral terms, scales the sum and moves it to a duty word centred on mid-scale. The result and a one-cycle valid pulse are registered at that edge. Computation therefore adds exactly one clock of delay, and the loop bandwidth is set by the switching period.

A signed controller output runs from full negative to full positive phase voltage. The block maps it onto an unsigned 8-bit duty, where 128 means zero average voltage, 0 means full negative and 255 means full positive. The proportional and integral gains are unsigned 8-bit inputs. The integrator magnitude limit is a run-time input. A synchronous clear zeroes the integrator. The asynchronous active-low reset is released through an internal two-stage synchroniser.

Top module: `pi_cur_reg`

## Requirements
- R1: After reset is released, duty_o is 128 and duty_vld_o is 0.
- R2: duty_vld_o is high for exactly the one cycle after each cycle in which smp_vld_i is high and clr_i is low, and is low otherwise.
- R3: The error is ref_i minus smp_i, both unsigned 12-bit, formed as a signed 13-bit value. Zero error with a zero integrator gives duty 128.
- R4: On an accepted sample, duty_o becomes clamp(128 + floor((kp_i*err + I_new) / 64), 0, 255). I_new is the updated integrator.
- R5: On each accepted sample the integrator changes by ki_i*err. The integrator is 24-bit signed and starts at zero.
- R6: The integrator is clamped to the range -ilim_i to +ilim_i. Once the error reverses, it recovers from the limit in a single sample.
- R7: The duty saturates at 0 for large negative sums and at 255 for large positive sums, with no wrap-around.
- R8: When clr_i is high the integrator becomes zero. A sample strobed in the same cycle is ignored: duty_vld_o stays low and duty_o holds.
- R9: When there is no accepted sample, duty_o holds its value, whatever the reference, sample or gain inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 12 | Current reference, unsigned |
| smp_i | input | 12 | Centre-aligned current sample, unsigned |
| smp_vld_i | input | 1 | Sample valid strobe |
| kp_i | input | 8 | Proportional gain, unsigned |
| ki_i | input | 8 | Integral gain, unsigned |
| ilim_i | input | 23 | Integrator magnitude limit |
| clr_i | input | 1 | Synchronous integrator clear |
| duty_o | output | 8 | Duty word, 128 = zero voltage |
| duty_vld_o | output | 1 | One-cycle pulse marking a new duty |

## Verification
Zero error shows that mid-scale offset alone sets the output. Equal positive and negative errors under a pure proportional gain separate floor rounding from truncation toward zero. A constant error repeated with only the integral gain active shows the accumulation from one sample to the next. A large error against a small limit, followed by a small reversed error, shows whether the anti-windup clamp acts on the stored integrator value. Full-scale errors with maximum gain expose wrap-around at the duty limits. Clears, clears coinciding with strobes, and input changes without a strobe expose updates that should not happen.

// File: rtl/pi_cur_pkg.sv
package pi_cur_pkg;
  // Integrator action for the current cycle
  typedef enum logic [1:0] {
    INT_HOLD  = 2'd0,
    INT_LOAD  = 2'd1,
    INT_CLEAR = 2'd2
  } int_act_e;
endpackage

// File: rtl/pi_err_calc.sv
module pi_err_calc #(
  parameter int SMP_W = 12
) (
  input  logic [SMP_W-1:0]      ref_i,
  input  logic [SMP_W-1:0]      smp_i,
  output logic signed [SMP_W:0] err_o
);
  always_comb begin
    err_o = $signed({1'b0, ref_i}) - $signed({1'b0, smp_i});
  end
endmodule

// File: rtl/pi_integrator.sv
module pi_integrator
  import pi_cur_pkg::*;
#(
  parameter int ERR_W  = 13,
  parameter int GAIN_W = 8,
  parameter int ACC_W  = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  int_act_e                act_i,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic [GAIN_W-1:0]       ki_i,
  input  logic [ACC_W-2:0]        lim_i,
  output logic signed [ACC_W-1:0] integ_q_o,
  output logic signed [ACC_W-1:0] integ_nxt_o
);
  localparam int PROD_W = ERR_W + GAIN_W + 1;
  localparam int SUM_W  = ACC_W + 1;

  logic signed [PROD_W-1:0] prod;
  logic signed [SUM_W-1:0]  raw_sum;
  logic signed [SUM_W-1:0]  lim_pos;
  logic signed [SUM_W-1:0]  lim_neg;
  logic signed [ACC_W-1:0]  integ_q;
  logic signed [ACC_W-1:0]  integ_d;

  always_comb begin
    prod    = PROD_W'(err_i) * $signed({1'b0, ki_i});
    raw_sum = SUM_W'(integ_q) + SUM_W'(prod);
    lim_pos = $signed({2'b00, lim_i});
    lim_neg = -lim_pos;
    if (raw_sum > lim_pos) begin
      integ_nxt_o = ACC_W'(lim_pos);
    end else if (raw_sum < lim_neg) begin
      integ_nxt_o = ACC_W'(lim_neg);
    end else begin
      integ_nxt_o = ACC_W'(raw_sum);
    end
  end

  always_comb begin
    case (act_i)
      INT_LOAD:  integ_d = integ_nxt_o;
      INT_CLEAR: integ_d = '0;
      default:   integ_d = integ_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_q <= '0;
    end else begin
      integ_q <= integ_d;
    end
  end

  assign integ_q_o = integ_q;
endmodule

// File: rtl/pi_out_scale.sv
module pi_out_scale #(
  parameter int ERR_W  = 13,
  parameter int GAIN_W = 8,
  parameter int ACC_W  = 24,
  parameter int SHIFT  = 6,
  parameter int DUTY_W = 8
) (
  input  logic signed [ERR_W-1:0] err_i,
  input  logic [GAIN_W-1:0]       kp_i,
  input  logic signed [ACC_W-1:0] integ_i,
  output logic [DUTY_W-1:0]       duty_o
);
  localparam int PROD_W = ERR_W + GAIN_W + 1;
  localparam int TOT_W  = ACC_W + 2;
  localparam int DMAX   = (1 << DUTY_W) - 1;
  localparam int DMID   = 1 << (DUTY_W - 1);

  logic signed [PROD_W-1:0] p_term;
  logic signed [TOT_W-1:0]  total;
  logic signed [TOT_W-1:0]  scaled;
  logic signed [TOT_W-1:0]  centred;

  always_comb begin
    p_term  = PROD_W'(err_i) * $signed({1'b0, kp_i});
    total   = TOT_W'(p_term) + TOT_W'(integ_i);
    scaled  = total >>> SHIFT;
    centred = scaled + TOT_W'(DMID);
    if (centred < 0) begin
      duty_o = '0;
    end else if (centred > TOT_W'(DMAX)) begin
      duty_o = DUTY_W'(DMAX);
    end else begin
      duty_o = DUTY_W'(centred);
    end
  end
endmodule

// File: rtl/pi_cur_reg.sv
module pi_cur_reg
  import pi_cur_pkg::*;
#(
  parameter int SMP_W  = 12,
  parameter int GAIN_W = 8,
  parameter int ACC_W  = 24,
  parameter int SHIFT  = 6,
  parameter int DUTY_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SMP_W-1:0]  ref_i,
  input  logic [SMP_W-1:0]  smp_i,
  input  logic              smp_vld_i,
  input  logic [GAIN_W-1:0] kp_i,
  input  logic [GAIN_W-1:0] ki_i,
  input  logic [ACC_W-2:0]  ilim_i,
  input  logic              clr_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic              duty_vld_o
);
  localparam int ERR_W = SMP_W + 1;
  localparam int DMID  = 1 << (DUTY_W - 1);

  // reset synchroniser: assert asynchronously, release on the clock
  logic [1:0] rst_pipe;
  logic       rst_sn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sn = rst_pipe[1];

  logic signed [ERR_W-1:0] err;
  logic signed [ACC_W-1:0] integ_q;
  logic signed [ACC_W-1:0] integ_nxt;
  logic [DUTY_W-1:0]       duty_nxt;
  logic                    upd_en;
  int_act_e                act;

  assign upd_en = smp_vld_i & ~clr_i;

  always_comb begin
    if (clr_i) begin
      act = INT_CLEAR;
    end else if (smp_vld_i) begin
      act = INT_LOAD;
    end else begin
      act = INT_HOLD;
    end
  end

  pi_err_calc #(.SMP_W(SMP_W)) u_err (
    .ref_i (ref_i),
    .smp_i (smp_i),
    .err_o (err)
  );

  pi_integrator #(.ERR_W(ERR_W), .GAIN_W(GAIN_W), .ACC_W(ACC_W)) u_int (
    .clk_i       (clk_i),
    .rst_ni      (rst_sn),
    .act_i       (act),
    .err_i       (err),
    .ki_i        (ki_i),
    .lim_i       (ilim_i),
    .integ_q_o   (integ_q),
    .integ_nxt_o (integ_nxt)
  );

  pi_out_scale #(.ERR_W(ERR_W), .GAIN_W(GAIN_W), .ACC_W(ACC_W),
                 .SHIFT(SHIFT), .DUTY_W(DUTY_W)) u_scale (
    .err_i   (err),
    .kp_i    (kp_i),
    .integ_i (integ_nxt),
    .duty_o  (duty_nxt)
  );

  logic [DUTY_W-1:0] duty_q, duty_d;
  logic              vld_q, vld_d;

  always_comb begin
    duty_d = upd_en ? duty_nxt : duty_q;
    vld_d  = upd_en;
  end

  always_ff @(posedge clk_i or negedge rst_sn) begin
    if (!rst_sn) begin
      duty_q <= DUTY_W'(DMID);
      vld_q  <= 1'b0;
    end else begin
      duty_q <= duty_d;
      vld_q  <= vld_d;
    end
  end

  assign duty_o     = duty_q;
  assign duty_vld_o = vld_q;
endmodule

// File: rtl/pi_cur_reg_chk.sv
module pi_cur_reg_chk #(
  parameter int SMP_W  = 12,
  parameter int ACC_W  = 24,
  parameter int DUTY_W = 8
) (
  input logic              clk,
  input logic              rst_sn,
  input logic              smp_vld,
  input logic              clr,
  input logic [SMP_W-1:0]  ref_v,
  input logic [SMP_W-1:0]  smp_v,
  input logic [DUTY_W-1:0] duty,
  input logic              duty_vld,
  input logic [ACC_W-1:0]  integ
);
  localparam int DMID = 1 << (DUTY_W - 1);

  // R2
  p_vld_pulse_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    (smp_vld && !clr) |=> duty_vld);
  p_vld_quiet_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    !(smp_vld && !clr) |=> !duty_vld);
  // R8
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    clr |=> (integ == '0));
  // R9
  p_duty_hold_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    !(smp_vld && !clr) |=> $stable(duty));
  // R3
  p_zero_err_mid_r3: assert property (@(posedge clk) disable iff (!rst_sn)
    (smp_vld && !clr && ref_v == smp_v && integ == '0) |=> (duty == DUTY_W'(DMID)));
endmodule

bind pi_cur_reg pi_cur_reg_chk #(.SMP_W(SMP_W), .ACC_W(ACC_W), .DUTY_W(DUTY_W)) u_chk (
  .clk      (clk_i),
  .rst_sn   (rst_sn),
  .smp_vld  (smp_vld_i),
  .clr      (clr_i),
  .ref_v    (ref_i),
  .smp_v    (smp_i),
  .duty     (duty_o),
  .duty_vld (duty_vld_o),
  .integ    (integ_q)
);

// File: tb/pi_cur_reg_tb.sv
module pi_cur_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] ref_v = '0, smp_v = '0;
  logic        vld = 1'b0, clr = 1'b0;
  logic [7:0]  kp = '0, ki = '0;
  logic [22:0] lim = 23'h7FFFFF;
  logic [7:0]  duty;
  logic        dvld;

  int checks = 0, fails = 0;
  longint m_int = 0;

  always #10 clk = ~clk;

  pi_cur_reg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_v), .smp_i(smp_v),
    .smp_vld_i(vld), .kp_i(kp), .ki_i(ki), .ilim_i(lim), .clr_i(clr),
    .duty_o(duty), .duty_vld_o(dvld)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model(input longint r, input longint s);
    longint e, t, sh, d;
    e = r - s;
    t = m_int + e * longint'(ki);
    if (t > longint'(lim)) t = longint'(lim);
    if (t < -longint'(lim)) t = -longint'(lim);
    m_int = t;
    sh = (e * longint'(kp) + t) >>> 6;
    d = sh + 128;
    if (d < 0) d = 0;
    if (d > 255) d = 255;
    return d;
  endfunction

  // one accepted sample, checked one clock later
  task automatic sample(input string req, input int r, input int s);
    longint exp;
    @(negedge clk);
    ref_v = 12'(r); smp_v = 12'(s); vld = 1'b1;
    exp = model(r, s);
    @(negedge clk);
    vld = 1'b0;
    chk(req, longint'(duty), exp);
    chk("R2", longint'(dvld), 1);
    @(negedge clk);
    chk("R2", longint'(dvld), 0);
  endtask

  task automatic do_clear();
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    m_int = 0;
  endtask

  task automatic t_reset();
    chk("R1", longint'(duty), 128);
    chk("R1", longint'(dvld), 0);
  endtask

  task automatic t_zero();
    kp = 8'd40; ki = 8'd0; do_clear();
    sample("R3", 1500, 1500);
  endtask

  task automatic t_prop();
    kp = 8'd4; ki = 8'd0; do_clear();
    sample("R4", 2000, 1000);  // +62 -> 190
    sample("R4", 1000, 2000);  // floor(-62.5) -> 65
    chk("R4", longint'(duty), 65);
  endtask

  task automatic t_integ();
    kp = 8'd0; ki = 8'd8; lim = 23'h7FFFFF; do_clear();
    sample("R5", 600, 500);   // 800 -> 140
    sample("R5", 600, 500);   // 1600 -> 153
    chk("R5", longint'(duty), 153);
    sample("R5", 500, 600);   // 800 -> 140
  endtask

  task automatic t_windup();
    kp = 8'd0; ki = 8'd8; lim = 23'd2000; do_clear();
    sample("R6", 3000, 2000); // clamp 2000 -> 159
    sample("R6", 3000, 2000);
    chk("R6", longint'(duty), 159);
    sample("R6", 2000, 2100); // 1200 -> 146
    chk("R6", longint'(duty), 146);
    do_clear();
    sample("R6", 0, 4000);    // clamp -2000 -> 96
    chk("R6", longint'(duty), 96);
    lim = 23'h7FFFFF;
  endtask

  task automatic t_sat();
    kp = 8'd255; ki = 8'd0; do_clear();
    sample("R7", 4095, 0);
    chk("R7", longint'(duty), 255);
    sample("R7", 0, 4095);
    chk("R7", longint'(duty), 0);
  endtask

  task automatic t_clear();
    longint held;
    kp = 8'd0; ki = 8'd16; do_clear();
    sample("R8", 700, 600);   // integ 1600 -> 153
    held = longint'(duty);
    @(negedge clk);
    clr = 1'b1; vld = 1'b1; ref_v = 12'd4000; smp_v = 12'd0;
    @(negedge clk);
    clr = 1'b0; vld = 1'b0; m_int = 0;
    chk("R8", longint'(dvld), 0);
    chk("R8", longint'(duty), held);
    sample("R8", 800, 800);   // integ was cleared -> 128
    chk("R8", longint'(duty), 128);
  endtask

  task automatic t_hold();
    longint held;
    kp = 8'd10; ki = 8'd0; do_clear();
    sample("R9", 1200, 1000); // 2000>>6=31 -> 159
    held = longint'(duty);
    @(negedge clk);
    ref_v = 12'd4095; smp_v = 12'd0; kp = 8'd255;
    repeat (5) @(negedge clk);
    chk("R9", longint'(duty), held);
    chk("R9", longint'(dvld), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_zero();
    t_prop();
    t_integ();
    t_windup();
    t_sat();
    t_clear();
    t_hold();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule